// File: doc/BRIEF.md
# Link arrival timestamp capture

This block measures the arrival latency of one serial front-end link. A local bunch-crossing counter steps once per clock across one orbit. An orbit-marker strobe clears it. The received word stream is tagged on every clock as either an IDLE word or a DATA word. After a reset command, the front end sends a burst of IDLE words (69 of them) in place of DATA. The first DATA word after that burst marks the point where the link's data begins. The block stores the counter value of that cycle as the link's arrival stamp.

The stamp uses a reserved code, 0xDEF, to mean "not valid". This code lies above the last bunch crossing of an orbit. The block loads the code at reset and again whenever the link's input delay setting changes. The code stays until a new IDLE-to-DATA transition is seen.

A stability monitor counts the clock cycles from each transition to the following delayed reset strobe. It compares that interval with the one measured before. If the two differ, it raises a sticky error flag.

Top module: `link_arrival_stamp`

## Requirements
- R1: The counter output `bcn` counts 0, 1, ..., 3563 and then returns to 0. It never shows a value above 3563.
- R2: A pulse on `orbit_mark` makes `bcn` read 0 on the following cycle.
- R3: An IDLE-to-DATA transition is a cycle with `word_is_data`=1 (DATA) whose previous cycle had `word_is_data`=0 (IDLE). On such a cycle, `arrival_bcn` takes that cycle's `bcn` value on the next cycle.
- R4: A pulse on `delay_changed` makes `arrival_bcn` read 0xDEF on the next cycle. This holds even when a transition happens in the same cycle.
- R5: Cycles that are IDLE after IDLE, DATA after DATA, or IDLE after DATA leave `arrival_bcn` unchanged.
- R6: `arrival_valid` is 1 exactly when `arrival_bcn` is not 0xDEF. After reset, `arrival_bcn` is 0xDEF and `interval_err` is 0.
- R7: The interval is the number of clock edges from a transition cycle to the first `ref_strobe` cycle after it. When an interval differs from the previous one, `interval_err` goes to 1 on the next cycle.
- R8: `interval_err` stays at 1 until `err_clear` is pulsed. If a mismatch and a clear fall in the same cycle, the mismatch wins.
- R9: A `delay_changed` pulse discards the stored reference interval. The next measured interval becomes the new baseline and raises no error.
- R10: A `ref_strobe` with no transition pending since the last strobe is ignored. It neither measures an interval nor changes the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| orbit_mark | input | 1 | Orbit-marker strobe that clears the counter |
| word_is_data | input | 1 | Tag of the received word: 1 = DATA, 0 = IDLE |
| delay_changed | input | 1 | Pulse when the link's input delay setting is changed |
| ref_strobe | input | 1 | Delayed reset strobe that closes an interval |
| err_clear | input | 1 | Pulse that clears the interval error |
| bcn | output | 12 | Current bunch-crossing number |
| arrival_bcn | output | 12 | Captured arrival stamp, 0xDEF when not valid |
| arrival_valid | output | 1 | Arrival stamp holds a measured value |
| interval_err | output | 1 | Sticky flag: the transition-to-strobe interval changed |

## Verification
The assertions assume that every input is a synchronous level or a one-cycle pulse that is sampled on the rising edge. They also assume that the word tag is defined in every cycle. They make no assumption about how far apart the strobes are. The bench changes inputs only on the falling edge. It builds IDLE bursts of realistic length and places `ref_strobe` a chosen number of cycles after each transition. It also runs one stretch longer than an orbit with no marker, so that the counter reaches its wrap. A cycle-accurate reference model in the bench follows all of these events.

// File: rtl/lat_pkg.sv
package lat_pkg;
  localparam int unsigned DEF_BCN_W     = 12;
  localparam int unsigned DEF_BCN_LAST  = 3563;
  localparam int unsigned DEF_BCN_NOVAL = 'hDEF;
  localparam int unsigned DEF_IV_W      = 12;

  typedef enum logic {
    MON_WAIT = 1'b0,
    MON_RUN  = 1'b1
  } mon_state_e;
endpackage

// File: rtl/bx_counter.sv
module bx_counter #(
  parameter int unsigned BCN_W    = lat_pkg::DEF_BCN_W,
  parameter int unsigned BCN_LAST = lat_pkg::DEF_BCN_LAST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             orbit_clr,
  output logic [BCN_W-1:0] bcn
);
  localparam logic [BCN_W-1:0] LAST = BCN_W'(BCN_LAST);
  localparam logic [BCN_W-1:0] ONE  = BCN_W'(1);

  function automatic logic [BCN_W-1:0] step_bcn(input logic [BCN_W-1:0] cur);
    return (cur >= LAST) ? '0 : cur + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         bcn <= '0;
    else if (orbit_clr) bcn <= '0;
    else                bcn <= step_bcn(bcn);
  end

  assert_bcn_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bcn <= LAST);
  assert_bcn_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bcn == LAST) |=> (bcn == '0));
  assert_orbit_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    orbit_clr |=> (bcn == '0));
endmodule

// File: rtl/arrival_capture.sv
module arrival_capture #(
  parameter int unsigned BCN_W     = lat_pkg::DEF_BCN_W,
  parameter int unsigned BCN_NOVAL = lat_pkg::DEF_BCN_NOVAL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_data,
  input  logic             delay_chg,
  input  logic [BCN_W-1:0] bcn,
  output logic             rise,
  output logic [BCN_W-1:0] arrival,
  output logic             valid
);
  localparam logic [BCN_W-1:0] NOVAL = BCN_W'(BCN_NOVAL);

  logic prev_data;

  function automatic logic is_rise(input logic prev, input logic cur);
    return !prev && cur;
  endfunction

  assign rise  = is_rise(prev_data, is_data);
  assign valid = (arrival != NOVAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_data <= 1'b1;
      arrival   <= NOVAL;
    end else begin
      prev_data <= is_data;
      if (delay_chg) arrival <= NOVAL;
      else if (rise) arrival <= bcn;
    end
  end

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !delay_chg) |=> (arrival == $past(bcn)));
  assert_invalidate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    delay_chg |=> (arrival == NOVAL));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !delay_chg) |=> $stable(arrival));
endmodule

// File: rtl/interval_check.sv
module interval_check #(
  parameter int unsigned IV_W = lat_pkg::DEF_IV_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic ref_strobe,
  input  logic delay_chg,
  input  logic err_clear,
  output logic interval_err
);
  import lat_pkg::*;

  localparam logic [IV_W-1:0] ONE  = IV_W'(1);
  localparam logic [IV_W-1:0] TOP  = '1;

  mon_state_e      state;
  logic [IV_W-1:0] run_cnt;
  logic [IV_W-1:0] ref_val;
  logic            have_ref;
  logic            close_iv;
  logic            mismatch;

  function automatic logic [IV_W-1:0] sat_inc(input logic [IV_W-1:0] v);
    return (v == TOP) ? v : v + ONE;
  endfunction

  assign close_iv = ref_strobe && (state == MON_RUN);
  assign mismatch = close_iv && have_ref && (run_cnt != ref_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= MON_WAIT;
      run_cnt      <= '0;
      ref_val      <= '0;
      have_ref     <= 1'b0;
      interval_err <= 1'b0;
    end else begin
      if (mismatch)       interval_err <= 1'b1;
      else if (err_clear) interval_err <= 1'b0;

      if (close_iv) ref_val <= run_cnt;

      if (delay_chg)     have_ref <= 1'b0;
      else if (close_iv) have_ref <= 1'b1;

      if (rise) begin
        state   <= MON_RUN;
        run_cnt <= ONE;
      end else if (close_iv) begin
        state <= MON_WAIT;
      end else if (state == MON_RUN) begin
        run_cnt <= sat_inc(run_cnt);
      end
    end
  end

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(interval_err) |-> $past(ref_strobe));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_err && !err_clear) |=> interval_err);
  assert_no_err_without_ref_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!have_ref && !interval_err && !err_clear) |=> !$rose(interval_err));
endmodule

// File: rtl/link_arrival_stamp.sv
module link_arrival_stamp #(
  parameter int unsigned BCN_W     = lat_pkg::DEF_BCN_W,
  parameter int unsigned BCN_LAST  = lat_pkg::DEF_BCN_LAST,
  parameter int unsigned BCN_NOVAL = lat_pkg::DEF_BCN_NOVAL,
  parameter int unsigned IV_W      = lat_pkg::DEF_IV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             orbit_mark,
  input  logic             word_is_data,
  input  logic             delay_changed,
  input  logic             ref_strobe,
  input  logic             err_clear,
  output logic [BCN_W-1:0] bcn,
  output logic [BCN_W-1:0] arrival_bcn,
  output logic             arrival_valid,
  output logic             interval_err
);
  logic first_data;

  bx_counter #(.BCN_W(BCN_W), .BCN_LAST(BCN_LAST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .orbit_clr(orbit_mark), .bcn(bcn)
  );

  arrival_capture #(.BCN_W(BCN_W), .BCN_NOVAL(BCN_NOVAL)) u_cap (
    .clk(clk), .rst_n(rst_n), .is_data(word_is_data), .delay_chg(delay_changed),
    .bcn(bcn), .rise(first_data), .arrival(arrival_bcn), .valid(arrival_valid)
  );

  interval_check #(.IV_W(IV_W)) u_mon (
    .clk(clk), .rst_n(rst_n), .rise(first_data), .ref_strobe(ref_strobe),
    .delay_chg(delay_changed), .err_clear(err_clear), .interval_err(interval_err)
  );
endmodule

// File: tb/link_arrival_stamp_tb_top.sv
`timescale 1ns/1ps
module link_arrival_stamp_tb_top;
  localparam int LAST  = 3563;
  localparam int NOVAL = 'hDEF;
  localparam int IVMAX = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic orbit_mark = 1'b0, word_is_data = 1'b1, delay_changed = 1'b0;
  logic ref_strobe = 1'b0, err_clear = 1'b0;
  logic [11:0] bcn, arrival_bcn;
  logic arrival_valid, interval_err;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  int m_bcn = 0, m_arr = NOVAL, m_run = 0, m_ref = 0;
  bit m_prev = 1'b1, m_armed = 1'b0, m_have = 1'b0, m_err = 1'b0;

  always #2 clk = ~clk;

  link_arrival_stamp dut_i (
    .clk(clk), .rst_n(rst_n), .orbit_mark(orbit_mark), .word_is_data(word_is_data),
    .delay_changed(delay_changed), .ref_strobe(ref_strobe), .err_clear(err_clear),
    .bcn(bcn), .arrival_bcn(arrival_bcn), .arrival_valid(arrival_valid),
    .interval_err(interval_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(int'(bcn) == m_bcn, "R1/R2 bcn", int'(bcn), m_bcn);
    chk(int'(arrival_bcn) == m_arr, "R3/R4/R5 arrival_bcn", int'(arrival_bcn), m_arr);
    chk(arrival_valid == (m_arr != NOVAL), "R6 arrival_valid", int'(arrival_valid), int'(m_arr != NOVAL));
    chk(interval_err == m_err, "R7/R8/R9/R10 interval_err", int'(interval_err), int'(m_err));
  endtask

  task automatic cyc(input bit d, input bit orb, input bit dly, input bit rs, input bit clr);
    bit trans, mism;
    int nbcn, narr;
    word_is_data = d; orbit_mark = orb; delay_changed = dly; ref_strobe = rs; err_clear = clr;
    @(posedge clk);
    trans = !m_prev && d;
    mism  = rs && m_armed && m_have && (m_run != m_ref);
    nbcn  = orb ? 0 : ((m_bcn == LAST) ? 0 : m_bcn + 1);
    narr  = dly ? NOVAL : (trans ? m_bcn : m_arr);
    if (mism) m_err = 1'b1; else if (clr) m_err = 1'b0;
    if (rs && m_armed) begin m_ref = m_run; m_have = 1'b1; m_armed = 1'b0; end
    if (dly) m_have = 1'b0;
    if (trans) begin m_armed = 1'b1; m_run = 1; end
    else if (m_armed) m_run = (m_run >= IVMAX) ? IVMAX : m_run + 1;
    m_prev = d; m_bcn = nbcn; m_arr = narr;
    @(negedge clk);
    compare_all();
  endtask

  task automatic data_n(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0);
  endtask

  // idle burst, transition, then ref_strobe k edges after the transition cycle
  task automatic burst(input int idle_n, input int k, input bit clr_at_strobe);
    for (int i = 0; i < idle_n; i++) cyc(0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    data_n(k - 1);
    cyc(1, 0, 0, 1, clr_at_strobe);
    data_n(5);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // reset state, R6
    chk(arrival_bcn == 12'hDEF, "R6 reset arrival", int'(arrival_bcn), NOVAL);
    chk(arrival_valid == 1'b0, "R6 reset valid", int'(arrival_valid), 0);
    chk(interval_err == 1'b0, "R6 reset err", int'(interval_err), 0);
    data_n(20);
    cyc(1, 1, 0, 0, 0);                    // R2 orbit clear
    data_n(10);
    cyc(1, 0, 0, 1, 0);                    // R10 strobe with nothing pending
    data_n(3);
    burst(69, 40, 0);                      // R3 first capture, baseline
    burst(69, 40, 0);                      // R7 equal interval
    burst(69, 40, 0);
    burst(69, 41, 0);                      // R7 changed interval
    data_n(20);                            // R8 sticky
    cyc(1, 0, 0, 0, 1);                    // R8 clear
    burst(69, 45, 1);                      // R8 mismatch wins over clear
    cyc(1, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0); // R5 data->idle, idle->idle
    cyc(1, 0, 0, 0, 0);                    // short-burst transition
    cyc(1, 0, 1, 0, 0);                    // R4 delay change
    data_n(5);
    burst(69, 30, 0);                      // R9 new baseline, no error
    burst(69, 30, 0);
    cyc(1, 0, 0, 1, 0);                    // R10 strobe again, nothing pending
    burst(10, 30, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(1, 0, 1, 0, 0);                    // R4 delay change with transition
    data_n(30);
    cyc(1, 0, 0, 1, 0);
    data_n(3700);                          // R1 wrap without orbit marker
    burst(69, 12, 0);
    cyc(1, 1, 0, 0, 0);
    data_n(10);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule